// File: doc/BRIEF.md
# Serial Converter Port (Device Side)

This block is the digital serial port of an analog-to-digital converter, seen from the converter's side of the wire. It runs entirely on the serial clock and is held in reset while the active-low chip select is high. Once chip select falls, it scans the data-in line for a start bit. It then takes in a short command that picks the input multiplexer arrangement and tells an abstracted converter core, through a one-cycle pulse, when to begin a conversion.

After that pulse the port shifts out two zero bits and then a parallel sample word, most significant bit first. The sample word is taken from an input port and frozen at the moment of the pulse. The port then keeps sending zeros for as long as the clock keeps running.

A parameter selects a fixed-configuration variant that takes no command at all. In that variant the first clock edge after chip select falls starts the output sequence. The output driver is modelled as a data bit plus an output enable, so the enclosing level can build the tri-state pad.

Top module: `adc_serial_port`

## Requirements
- R1: Chip select high (`cs_n`=1) resets the port asynchronously: `sdo_oe`=0, `sdo`=0, `conv_start`=0, `mux_pos`=0, `mux_neg`=0. Every low period of `cs_n` begins a fresh exchange.
- R2: Data-in zeros sampled on rising `sclk` edges before the first one are ignored. The first `sdi`=1 is the start bit. Until the multiplexer bits have arrived, both multiplexer outputs read 0 and `sdo_oe` is 0.
- R3: The first bit after the start bit is the mode bit (1 = single-ended, 0 = differential). The second is the odd/sign bit. The decoded selection appears on `mux_pos`/`mux_neg` from the edge that captures the odd/sign bit. Encoding: `mux_pos` bit0 = channel 0 positive, bit1 = channel 1 positive; `mux_neg` bit0 = channel 0 negative, bit1 = channel 1 negative, bit2 = ground reference.
- R4: Single-ended decode: odd/sign 0 gives `mux_pos`=01, `mux_neg`=100. Odd/sign 1 gives `mux_pos`=10, `mux_neg`=100.
- R5: Differential decode: odd/sign 0 gives `mux_pos`=01, `mux_neg`=010. Odd/sign 1 gives `mux_pos`=10, `mux_neg`=001.
- R6: The two bits after odd/sign are don't-care filler. After them, `sdi` has no effect on any output (including further ones) until `cs_n` rises.
- R7: On the edge that takes the second filler bit, `conv_start` is high for exactly one cycle, `sdo_oe` rises and `sdo` is 0 (first null bit). The next edge gives a second 0. The next `RES` edges give the sample, most significant bit first, one bit per rising edge.
- R8: After the least significant bit, `sdo` stays 0 on every further edge while `cs_n` is low.
- R9: The sample is captured from `sample_in` on the `conv_start` edge. Later changes of `sample_in` do not alter the bits sent.
- R10: With `FIXED_CFG`=1, `sdi` is ignored. The first rising edge after `cs_n` falls performs the R7 start (pulse, enable, first null bit). The multiplexer outputs report differential channel 0 positive, channel 1 negative from that edge.
- R11: Once raised, `sdo_oe` stays 1 until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Active-low chip select; high is an asynchronous reset |
| sclk | input | 1 | Serial clock, rising edge active |
| sdi | input | 1 | Serial command input |
| sample_in | input | RES | Parallel result from the converter core |
| sdo | output | 1 | Serial data output bit |
| sdo_oe | output | 1 | Output enable for the data pad |
| conv_start | output | 1 | One-cycle pulse telling the core to convert |
| mux_pos | output | 2 | One-hot positive input channel |
| mux_neg | output | 3 | One-hot negative input (ch0, ch1, ground) |

## Verification
Two events coincide at the convert-start edge. On that edge the sample word is captured, while the stimulus changes `sample_in` just afterwards, ahead of the next edge. The scoreboard expects the frozen value on every result bit, so a capture taken one edge late shows up as inverted bits. A second coincidence comes from the last filler bit: `sdi` carries a one on the same edge as the pulse, and further ones follow it. These are judged by `conv_start` pulsing once and the multiplexer outputs staying put.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_CMD  = 2'd1,
        ST_XFER = 2'd2,
        ST_PAD  = 2'd3
    } phase_e;

    // command bits that follow the start bit: mode, odd/sign, two fillers
    localparam int CMD_BITS = 4;

    localparam logic [1:0] POS_NONE = 2'b00;
    localparam logic [1:0] POS_CH0  = 2'b01;
    localparam logic [1:0] POS_CH1  = 2'b10;
    localparam logic [2:0] NEG_NONE = 3'b000;
    localparam logic [2:0] NEG_CH0  = 3'b001;
    localparam logic [2:0] NEG_CH1  = 3'b010;
    localparam logic [2:0] NEG_GND  = 3'b100;

endpackage

// File: rtl/adc_sp_mux_decode.sv
module adc_sp_mux_decode
    import adc_sp_pkg::*;
(
    input  logic       cfg_ok,
    input  logic       single,
    input  logic       odd,
    output logic [1:0] pos,
    output logic [2:0] neg
);

    always_comb begin
        pos = POS_NONE;
        neg = NEG_NONE;
        if (cfg_ok) begin
            pos = odd ? POS_CH1 : POS_CH0;
            if (single) begin
                neg = NEG_GND;
            end else begin
                neg = odd ? NEG_CH0 : NEG_CH1;
            end
        end
    end

endmodule

// File: rtl/adc_sp_seq.sv
module adc_sp_seq
    import adc_sp_pkg::*;
#(
    parameter int RES       = 8,
    parameter bit FIXED_CFG = 1'b0
) (
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           sdi,
    input  logic [RES-1:0] sample_in,
    output logic           dout,
    output logic           oe,
    output logic           conv,
    output logic           cfg_ok,
    output logic           single,
    output logic           odd
);

    localparam int CW = $clog2(RES + CMD_BITS + 1);
    localparam int SW = RES + 1;

    typedef struct packed {
        phase_e          st;
        logic [CW-1:0]   cnt;
        logic            single;
        logic            odd;
        logic            cfg_ok;
        logic            oe;
        logic            dout;
        logic            conv;
        logic [SW-1:0]   sh;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_HUNT, cnt: '0, single: 1'b0, odd: 1'b0, cfg_ok: 1'b0,
        oe: 1'b0, dout: 1'b0, conv: 1'b0, sh: '0
    };

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.conv = 1'b0;
        unique case (seq_q.st)
            ST_HUNT: begin
                if (FIXED_CFG) begin
                    seq_d.single = 1'b0;
                    seq_d.odd    = 1'b0;
                    seq_d.cfg_ok = 1'b1;
                    seq_d.st     = ST_XFER;
                    seq_d.cnt    = '0;
                    seq_d.oe     = 1'b1;
                    seq_d.dout   = 1'b0;
                    seq_d.conv   = 1'b1;
                    seq_d.sh     = {1'b0, sample_in};
                end else if (sdi) begin
                    seq_d.st  = ST_CMD;
                    seq_d.cnt = '0;
                end
            end
            ST_CMD: begin
                if (seq_q.cnt == CW'(0)) begin
                    seq_d.single = sdi;
                end
                if (seq_q.cnt == CW'(1)) begin
                    seq_d.odd    = sdi;
                    seq_d.cfg_ok = 1'b1;
                end
                if (seq_q.cnt == CW'(CMD_BITS - 1)) begin
                    seq_d.st   = ST_XFER;
                    seq_d.cnt  = '0;
                    seq_d.oe   = 1'b1;
                    seq_d.dout = 1'b0;
                    seq_d.conv = 1'b1;
                    seq_d.sh   = {1'b0, sample_in};
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            ST_XFER: begin
                seq_d.dout = seq_q.sh[SW-1];
                seq_d.sh   = {seq_q.sh[SW-2:0], 1'b0};
                seq_d.cnt  = seq_q.cnt + CW'(1);
                if (seq_q.cnt == CW'(RES)) begin
                    seq_d.st = ST_PAD;
                end
            end
            ST_PAD: begin
                seq_d.dout = 1'b0;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dout   = seq_q.dout;
    assign oe     = seq_q.oe;
    assign conv   = seq_q.conv;
    assign cfg_ok = seq_q.cfg_ok;
    assign single = seq_q.single;
    assign odd    = seq_q.odd;

    // R7: the start pulse lasts a single cycle
    assert_conv_single_R7: assert property (@(posedge sclk) disable iff (cs_n)
        conv |=> !conv);

    // R7: the pulse edge drives the first null bit with the pad enabled
    assert_conv_null_R7: assert property (@(posedge sclk) disable iff (cs_n)
        conv |-> (oe && !dout));

    // R7: the edge after the pulse still carries a null bit
    assert_second_null_R7: assert property (@(posedge sclk) disable iff (cs_n)
        $past(conv) |-> !dout);

    // R6: once captured, the configuration never moves within the exchange
    assert_cfg_frozen_R6: assert property (@(posedge sclk) disable iff (cs_n)
        (cfg_ok && $past(cfg_ok)) |-> ($stable(single) && $stable(odd)));

    // R8: padding phase only ever emits zeros
    assert_pad_zero_R8: assert property (@(posedge sclk) disable iff (cs_n)
        (seq_q.st == ST_PAD) |=> !dout);

    // R11: the enable never drops while chip select stays low
    assert_oe_hold_R11: assert property (@(posedge sclk) disable iff (cs_n)
        oe |=> oe);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int RES       = 8,
    parameter bit FIXED_CFG = 1'b0
) (
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           sdi,
    input  logic [RES-1:0] sample_in,
    output logic           sdo,
    output logic           sdo_oe,
    output logic           conv_start,
    output logic [1:0]     mux_pos,
    output logic [2:0]     mux_neg
);

    logic cfg_ok;
    logic single;
    logic odd;

    adc_sp_seq #(
        .RES       (RES),
        .FIXED_CFG (FIXED_CFG)
    ) i_seq (
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sample_in (sample_in),
        .dout      (sdo),
        .oe        (sdo_oe),
        .conv      (conv_start),
        .cfg_ok    (cfg_ok),
        .single    (single),
        .odd       (odd)
    );

    adc_sp_mux_decode i_dec (
        .cfg_ok (cfg_ok),
        .single (single),
        .odd    (odd),
        .pos    (mux_pos),
        .neg    (mux_neg)
    );

    // R3: at most one positive and one negative input chosen
    assert_mux_onehot_R3: assert property (@(posedge sclk) disable iff (cs_n)
        $onehot0(mux_pos) && $onehot0(mux_neg));

    // R3: positive and negative selections appear together
    assert_mux_paired_R3: assert property (@(posedge sclk) disable iff (cs_n)
        (|mux_pos) == (|mux_neg));

    // R2: the pad is not driven before the selection is known
    assert_oe_after_cfg_R2: assert property (@(posedge sclk) disable iff (cs_n)
        sdo_oe |-> (|mux_pos));

endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;

    localparam int RES = 8;

    typedef struct {
        int         k;
        logic       oe, sdo, conv;
        logic [1:0] pos;
        logic [2:0] neg;
        logic       f_oe, f_sdo, f_conv;
        logic [1:0] f_pos;
        logic [2:0] f_neg;
        string      tag;
    } exp_t;

    logic           sclk = 1'b0;
    logic           cs_n = 1'b0;
    logic           sdi  = 1'b0;
    logic [RES-1:0] sample_in = '0;
    logic           sdo, sdo_oe, conv_start;
    logic [1:0]     mux_pos;
    logic [2:0]     mux_neg;
    logic           f_sdo, f_oe, f_conv;
    logic [1:0]     f_pos;
    logic [2:0]     f_neg;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #5 sclk = ~sclk;

    adc_serial_port #(.RES(RES), .FIXED_CFG(1'b0)) i_adc_serial_port (
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sample_in(sample_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start),
        .mux_pos(mux_pos), .mux_neg(mux_neg));

    adc_serial_port #(.RES(RES), .FIXED_CFG(1'b1)) i_adc_serial_port_fixed (
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sample_in(sample_in),
        .sdo(f_sdo), .sdo_oe(f_oe), .conv_start(f_conv),
        .mux_pos(f_pos), .mux_neg(f_neg));

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // selection table written from R4/R5
    function automatic logic [4:0] sel(input logic single, input logic odd);
        if (single) return odd ? 5'b10_100 : 5'b01_100;
        return odd ? 5'b10_001 : 5'b01_010;
    endfunction

    // expected serial bit at edge k when the start edge is ld
    function automatic logic bit_at(input int k, input int ld,
                                    input logic [RES-1:0] smp);
        int j;
        j = k - ld - 1;
        if (j >= 1 && j <= RES) return smp[RES - j];
        return 1'b0;
    endfunction

    // monitor: pops one expected item per falling edge
    always @(negedge sclk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(sdo_oe == e.oe, "R11", $sformatf("oe k=%0d", e.k), sdo_oe, e.oe);
            chk(sdo == e.sdo, e.tag, $sformatf("sdo k=%0d", e.k), sdo, e.sdo);
            chk(conv_start == e.conv, "R7", $sformatf("conv k=%0d", e.k), conv_start, e.conv);
            chk({mux_pos, mux_neg} == {e.pos, e.neg}, "R3",
                $sformatf("mux k=%0d", e.k), {mux_pos, mux_neg}, {e.pos, e.neg});
            chk({f_oe, f_sdo, f_conv, f_pos, f_neg} ==
                {e.f_oe, e.f_sdo, e.f_conv, e.f_pos, e.f_neg}, "R10",
                $sformatf("fixed k=%0d", e.k),
                {f_oe, f_sdo, f_conv, f_pos, f_neg},
                {e.f_oe, e.f_sdo, e.f_conv, e.f_pos, e.f_neg});
        end
    end

    task automatic idle_check(input string why);
        chk({sdo_oe, sdo, conv_start, mux_pos, mux_neg} == '0, "R1",
            {"reset full ", why}, {sdo_oe, sdo, conv_start, mux_pos, mux_neg}, 0);
        chk({f_oe, f_sdo, f_conv, f_pos, f_neg} == '0, "R1",
            {"reset fixed ", why}, {f_oe, f_sdo, f_conv, f_pos, f_neg}, 0);
    endtask

    // driver: one chip-select low period of n edges
    task automatic exchange(input int lead, input logic single, input logic odd,
                            input logic [RES-1:0] smp, input logic [3:0] junk,
                            input int n);
        int s, ld;
        s  = lead + 1;
        ld = s + 4;
        sample_in = smp;
        @(negedge sclk);
        #1;
        cs_n = 1'b0;
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            if (k <= lead)          sdi = 1'b0;
            else if (k == s)        sdi = 1'b1;
            else if (k == s + 1)    sdi = single;
            else if (k == s + 2)    sdi = odd;
            else                    sdi = junk[k % 4];
            // R9: change the port right after the capture edge
            if (k == ld + 1) sample_in = ~smp;
            e.k    = k;
            e.oe   = (k >= ld);
            e.conv = (k == ld);
            e.sdo  = bit_at(k, ld, smp);
            e.tag  = (k - ld - 1 > RES) ? "R8" : (k <= ld + 1 ? "R7" : "R9");
            {e.pos, e.neg} = (k >= s + 2) ? sel(single, odd) : 5'b0;
            e.f_oe   = 1'b1;
            e.f_conv = (k == 1);
            e.f_sdo  = bit_at(k, 1, smp);
            {e.f_pos, e.f_neg} = sel(1'b0, 1'b0);
            sb.push_back(e);
            if (k == s) chk(sdo_oe == 1'b0, "R2", "oe before start", sdo_oe, 0);
            @(negedge sclk);
            #1;
        end
        chk(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
        cs_n = 1'b1;
        sdi  = 1'b0;
        #1;
        idle_check("after exchange");
        @(negedge sclk);
    endtask

    initial begin
        #2;
        cs_n = 1'b1;
        #10;
        idle_check("power up");
        exchange(0, 1'b1, 1'b0, 8'hA5, 4'b1111, 25);   // R4 single ch0, ones after fillers R6
        exchange(3, 1'b1, 1'b1, 8'h3C, 4'b1010, 22);   // R4 single ch1, R2 leading zeros
        exchange(5, 1'b0, 1'b0, 8'hFF, 4'b0110, 30);   // R5 diff ch0+, R8 long pad
        exchange(1, 1'b0, 1'b1, 8'h81, 4'b1111, 20);   // R5 diff ch1+
        exchange(2, 1'b1, 1'b0, 8'h00, 4'b1111, 4);    // R1 abort inside command
        exchange(0, 1'b0, 1'b1, 8'h5A, 4'b1011, 18);   // R1 fresh exchange after abort
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule